// File: doc/BRIEF.md
# Dual Tone Cadence Timer

This block paces the on/off rhythm of two independent tone oscillators. Each channel holds a duration for its tone-on period and one for its silent period, both counted in sample-rate ticks. While a channel's run bit is set, its gate output turns the oscillator on for the on duration and off for the off duration, and keeps repeating. The gate stays low while the run bit is clear.

Whenever a period ends, a pending flag is raised for that channel and that edge. Software picks which pending flags reach the single interrupt line through an enable register. It clears flags by writing ones to the status register. A zero off duration gives a steady tone. A zero on duration holds the gate on and raises no flags. All settings go through a small register port with a combinational read path.

Top module: `toneCadenceTimer`

## Requirements
- R1: After reset every register reads zero, both gates are low and the interrupt line is low.
- R2: Register map (3-bit address, 16-bit data): address 2c holds the on duration of channel c and 2c+1 its off duration (channel 1 is c=0, channel 2 is c=1). Address 4 bits [1:0] are the run bits (bit 0 runs channel 1). Address 5 bits [3:0] are the interrupt enables. Address 6 bits [3:0] are the pending flags. Address 7 and all unused bits read zero. Reads are combinational on the address, and written values read back after the write edge.
- R3: Suppose a run bit is written to 1 at clock edge w. The channel's gate then rises after edge w+1. It stays high for as many ticks as the on duration and low for as many ticks as the off duration, and the cycle repeats.
- R4: If a run bit is written to 0 at edge w, the gate is low after edge w+1 and no flag for that channel is raised at that edge. A later restart begins with an on period.
- R5: Flag bits are ordered bit 0 channel 1 on-period end, bit 1 channel 1 off-period end, bit 2 channel 2 on-period end, bit 3 channel 2 off-period end. A flag is set at the edge its period ends, whatever the enable bits hold.
- R6: Writing 1 to a flag bit at address 6 clears it, and writing 0 leaves it unchanged. If a flag's own event and a clear of it fall on the same edge, the flag ends up set.
- R7: The interrupt line is high exactly when some flag and its enable bit are both set, in the same cycle as the registers change.
- R8: With a zero off duration the gate stays high, an on-period-end flag is raised after every on duration, and no off-period-end flag is raised.
- R9: With a zero on duration the running gate stays high and the channel raises no flags.
- R10: Period counters advance only on clock edges where tick is high. Without ticks a running gate does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at the sample rate |
| regAddr | input | 3 | Register address for read and write |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr |
| toneGate | output | 2 | Oscillator gate per channel, bit 0 is channel 1 |
| irq | output | 1 | Combined masked interrupt |

## Verification
A period ending and a software write of ones to the flag register can land on the same clock edge. The bench predicts, from its own model of the counters, the edges where a flag will be raised. On some of those edges it drives a clear of exactly that flag, both in a directed run and at random. Right after such an edge it reads the flag register and expects the bit still set. A following clear with no event pending must leave it zero.

// File: rtl/toneCadencePkg.sv
package toneCadencePkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } phase_t;

  // Strobes from the cadence control to the datapath, one set per channel.
  typedef struct packed {
    logic loadOn;   // load counter with the on duration
    logic loadOff;  // load counter with the off duration
    logic decr;     // count one tick down
    logic onEvt;    // on period ended
    logic offEvt;   // off period ended
  } chStrobe_t;

endpackage

// File: rtl/cadenceCtrl.sv
module cadenceCtrl
  import toneCadencePkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic [NUM_CH-1:0]      runEn,
  input  logic [NUM_CH-1:0]      cntLast,
  input  logic [NUM_CH-1:0]      onZero,
  input  logic [NUM_CH-1:0]      offZero,
  output chStrobe_t [NUM_CH-1:0] strb,
  output logic [NUM_CH-1:0]      toneGate
);

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    phase_t    phQ, phD;
    chStrobe_t s;

    always_comb begin
      s   = '0;
      phD = phQ;
      if (!runEn[c]) begin
        phD = PH_IDLE;
      end else begin
        unique case (phQ)
          PH_IDLE: begin
            s.loadOn = 1'b1;
            phD      = PH_ON;
          end
          PH_ON: begin
            if (tick && !onZero[c]) begin
              if (cntLast[c]) begin
                s.onEvt = 1'b1;
                if (offZero[c]) begin
                  s.loadOn = 1'b1;
                end else begin
                  s.loadOff = 1'b1;
                  phD       = PH_OFF;
                end
              end else begin
                s.decr = 1'b1;
              end
            end
          end
          PH_OFF: begin
            if (tick) begin
              if (cntLast[c]) begin
                s.offEvt = 1'b1;
                s.loadOn = 1'b1;
                phD      = PH_ON;
              end else begin
                s.decr = 1'b1;
              end
            end
          end
          default: phD = PH_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) phQ <= PH_IDLE;
      else       phQ <= phD;
    end

    assign strb[c]     = s;
    assign toneGate[c] = (phQ == PH_ON);
  end

endmodule

// File: rtl/cadenceData.sv
module cadenceData
  import toneCadencePkg::*;
#(
  parameter  int NUM_CH = 2,
  parameter  int DUR_W  = 16,
  localparam int NUM_DUR = 2 * NUM_CH,
  localparam int ADDR_W  = $clog2(NUM_DUR + 3)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic                   regWrEn,
  input  logic [DUR_W-1:0]       regWrData,
  output logic [DUR_W-1:0]       regRdData,
  input  chStrobe_t [NUM_CH-1:0] strb,
  output logic [NUM_CH-1:0]      runEn,
  output logic [NUM_CH-1:0]      cntLast,
  output logic [NUM_CH-1:0]      onZero,
  output logic [NUM_CH-1:0]      offZero,
  output logic [NUM_DUR-1:0]     pendBits,
  output logic [NUM_DUR-1:0]     enBits
);

  localparam logic [ADDR_W-1:0] RUN_ADDR  = ADDR_W'(NUM_DUR);
  localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(NUM_DUR + 1);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_DUR + 2);

  logic [DUR_W-1:0]   durQ [NUM_DUR];
  logic [DUR_W-1:0]   cntQ [NUM_CH];
  logic [NUM_CH-1:0]  runQ;
  logic [NUM_DUR-1:0] enQ, pendQ, evtVec, clrMask;

  for (genvar i = 0; i < NUM_DUR; i++) begin : gDur
    always_ff @(posedge clk) begin
      if (!rstN)                                     durQ[i] <= '0;
      else if (regWrEn && regAddr == ADDR_W'(i))     durQ[i] <= regWrData;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gCnt
    always_ff @(posedge clk) begin
      if (!rstN)                cntQ[c] <= '0;
      else if (strb[c].loadOn)  cntQ[c] <= durQ[2*c];
      else if (strb[c].loadOff) cntQ[c] <= durQ[2*c+1];
      else if (strb[c].decr)    cntQ[c] <= cntQ[c] - DUR_W'(1);
    end
    assign cntLast[c]     = (cntQ[c] <= DUR_W'(1));
    assign onZero[c]      = (durQ[2*c] == '0);
    assign offZero[c]     = (durQ[2*c+1] == '0);
    assign evtVec[2*c]    = strb[c].onEvt;
    assign evtVec[2*c+1]  = strb[c].offEvt;
  end

  assign clrMask = (regWrEn && regAddr == STAT_ADDR) ? regWrData[NUM_DUR-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= '0;
      enQ   <= '0;
      pendQ <= '0;
    end else begin
      if (regWrEn && regAddr == RUN_ADDR) runQ <= regWrData[NUM_CH-1:0];
      if (regWrEn && regAddr == EN_ADDR)  enQ  <= regWrData[NUM_DUR-1:0];
      pendQ <= (pendQ & ~clrMask) | evtVec;
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_DUR; i++) begin
      if (regAddr == ADDR_W'(i)) regRdData = durQ[i];
    end
    if (regAddr == RUN_ADDR)  regRdData = DUR_W'(runQ);
    if (regAddr == EN_ADDR)   regRdData = DUR_W'(enQ);
    if (regAddr == STAT_ADDR) regRdData = DUR_W'(pendQ);
  end

  assign runEn    = runQ;
  assign pendBits = pendQ;
  assign enBits   = enQ;

endmodule

// File: rtl/toneCadenceTimer.sv
module toneCadenceTimer
  import toneCadencePkg::*;
#(
  parameter  int NUM_CH = 2,
  parameter  int DUR_W  = 16,
  localparam int ADDR_W = $clog2(2 * NUM_CH + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DUR_W-1:0]  regWrData,
  output logic [DUR_W-1:0]  regRdData,
  output logic [NUM_CH-1:0] toneGate,
  output logic              irq
);

  chStrobe_t [NUM_CH-1:0] strb;
  logic [NUM_CH-1:0]      runEn, cntLast, onZero, offZero;
  logic [2*NUM_CH-1:0]    pendBits, enBits;

  cadenceCtrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .runEn(runEn), .cntLast(cntLast), .onZero(onZero), .offZero(offZero),
    .strb(strb), .toneGate(toneGate)
  );

  cadenceData #(.NUM_CH(NUM_CH), .DUR_W(DUR_W)) uData (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .strb(strb), .runEn(runEn), .cntLast(cntLast), .onZero(onZero), .offZero(offZero),
    .pendBits(pendBits), .enBits(enBits)
  );

  assign irq = |(pendBits & enBits);

endmodule

// File: rtl/toneCadenceChk.sv
module toneCadenceChk
  import toneCadencePkg::*;
#(
  parameter  int NUM_CH = 2,
  localparam int NUM_DUR = 2 * NUM_CH,
  localparam int ADDR_W  = $clog2(NUM_DUR + 3)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   tick,
  input logic [ADDR_W-1:0]      regAddr,
  input logic                   regWrEn,
  input logic [NUM_DUR-1:0]     clrData,
  input logic [NUM_CH-1:0]      toneGate,
  input logic [NUM_DUR-1:0]     pendBits,
  input chStrobe_t [NUM_CH-1:0] strb
);

  logic [NUM_DUR-1:0] evtVec, clrMask;

  for (genvar c = 0; c < NUM_CH; c++) begin : gEv
    assign evtVec[2*c]   = strb[c].onEvt;
    assign evtVec[2*c+1] = strb[c].offEvt;

    AST_OFF_END_GATE_ON: assert property (@(posedge clk) disable iff (!rstN)
      strb[c].offEvt |=> toneGate[c]); // R3
  end

  assign clrMask = (regWrEn && regAddr == ADDR_W'(NUM_DUR + 2)) ? clrData : '0;

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(pendBits) & ~$past(clrMask) & ~pendBits) == '0)); // R6

  AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (($past(evtVec) & ~pendBits) == '0)); // R5

  AST_GATE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(tick) && !$past(regWrEn) && !$past(regWrEn, 2)) |-> $stable(toneGate)); // R10

endmodule

bind toneCadenceTimer toneCadenceChk #(.NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .regAddr(regAddr), .regWrEn(regWrEn),
  .clrData(regWrData[2*NUM_CH-1:0]), .toneGate(toneGate), .pendBits(pendBits), .strb(strb)
);

// File: tb/sim_toneCadenceTimer.sv
module sim_toneCadenceTimer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [1:0]  toneGate;
  logic        irq;

  int nChk = 0;
  int nFail = 0;
  int nColl = 0;
  bit done = 0;

  always #5 clk = ~clk;

  toneCadenceTimer u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .toneGate(toneGate), .irq(irq)
  );

  // Reference model of the requirements, advanced at each rising edge.
  logic [15:0] mDur [4];
  logic [1:0]  mRun;
  logic [3:0]  mEn, mPend, mEvt;
  int          mPh [2];   // 0 idle, 1 on, 2 off
  logic [15:0] mCnt [2];

  function automatic logic [3:0] predEvt(logic tk);
    logic [3:0] e = '0;
    for (int c = 0; c < 2; c++) begin
      if (mRun[c] && tk && mCnt[c] <= 16'd1) begin
        if (mPh[c] == 1 && mDur[2*c] != 16'd0) e[2*c] = 1'b1;
        if (mPh[c] == 2)                       e[2*c+1] = 1'b1;
      end
    end
    return e;
  endfunction

  function automatic logic [15:0] mRd(logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd2, 3'd3: return mDur[a[1:0]];
      3'd4: return {14'd0, mRun};
      3'd5: return {12'd0, mEn};
      3'd6: return {12'd0, mPend};
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mDur[i] = '0;
      for (int c = 0; c < 2; c++) begin mPh[c] = 0; mCnt[c] = '0; end
      mRun = '0; mEn = '0; mPend = '0;
    end else begin
      mEvt = predEvt(tick);
      for (int c = 0; c < 2; c++) begin
        if (!mRun[c]) mPh[c] = 0;
        else if (mPh[c] == 0) begin mPh[c] = 1; mCnt[c] = mDur[2*c]; end
        else if (tick && mPh[c] == 1 && mDur[2*c] != 16'd0) begin
          if (mCnt[c] <= 16'd1) begin
            if (mDur[2*c+1] == 16'd0) mCnt[c] = mDur[2*c];
            else begin mPh[c] = 2; mCnt[c] = mDur[2*c+1]; end
          end else mCnt[c] = mCnt[c] - 16'd1;
        end else if (tick && mPh[c] == 2) begin
          if (mCnt[c] <= 16'd1) begin mPh[c] = 1; mCnt[c] = mDur[2*c]; end
          else mCnt[c] = mCnt[c] - 16'd1;
        end
      end
      mPend = (mPend & ~((regWrEn && regAddr == 3'd6) ? regWrData[3:0] : 4'd0)) | mEvt;
      if (regWrEn) begin
        if (regAddr < 3'd4) mDur[regAddr[1:0]] = regWrData;
        if (regAddr == 3'd4) mRun = regWrData[1:0];
        if (regAddr == 3'd5) mEn = regWrData[3:0];
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare against the model, then drive the inputs for the next edge.
  task automatic step(logic tk, logic we, logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    if (rstN) begin
      chk("R3 gate vs model", {14'd0, toneGate}, {14'd0, mPh[1] == 1, mPh[0] == 1});
      chk("R7 irq vs model", {15'd0, irq}, {15'd0, |(mPend & mEn)});
      chk("R2 readback vs model", regRdData, mRd(regAddr));
    end
    tick = tk; regWrEn = we; regAddr = a; regWrData = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd6, 16'd0);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic ever;
    logic [3:0] prevE;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every address and outputs
    for (int a = 0; a < 8; a++) begin
      step(1'b0, 1'b0, 3'(a), 16'd0);
      #1 chk("R1 reset readback", regRdData, 16'd0);
    end
    chk("R1 reset gate", {14'd0, toneGate}, 16'd0);
    chk("R1 reset irq", {15'd0, irq}, 16'd0);

    // R2: write/readback of every register
    step(1'b0, 1'b1, 3'd3, 16'hBEEF);
    step(1'b0, 1'b1, 3'd5, 16'hFFFF);
    step(1'b0, 1'b0, 3'd3, 16'd0);
    #1 chk("R2 duration readback", regRdData, 16'hBEEF);
    step(1'b0, 1'b0, 3'd5, 16'd0);
    #1 chk("R2 enable readback width", regRdData, 16'h000F);

    // R8: zero off duration gives steady tone, only on-end flags
    step(1'b0, 1'b1, 3'd0, 16'd2);
    step(1'b0, 1'b1, 3'd1, 16'd0);
    step(1'b0, 1'b1, 3'd4, 16'd1);
    ever = 1'b0;
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 1'b0, 3'd6, 16'd0);
      if (i >= 1 && !toneGate[0]) ever = 1'b1;
    end
    chk("R8 gate never dropped", {15'd0, ever}, 16'd0);
    #1 chk("R8 flags on-end only", regRdData & 16'h3, 16'h1);

    // R6 plain clear, then R4 stop
    step(1'b0, 1'b1, 3'd6, 16'hF);
    step(1'b0, 1'b1, 3'd4, 16'd0);
    idle(2);
    chk("R4 gate low after stop", {15'd0, toneGate[0]}, 16'd0);
    #1 chk("R6 flags cleared", regRdData, 16'd0);

    // R9: zero on duration
    step(1'b0, 1'b1, 3'd0, 16'd0);
    step(1'b0, 1'b1, 3'd1, 16'd5);
    step(1'b0, 1'b1, 3'd4, 16'd1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 3'd6, 16'd0);
    chk("R9 gate held on", {15'd0, toneGate[0]}, 16'd1);
    #1 chk("R9 no flags", regRdData, 16'd0);
    step(1'b0, 1'b1, 3'd4, 16'd0);
    idle(2);

    // R10: no ticks freeze the cadence
    step(1'b0, 1'b1, 3'd0, 16'd3);
    step(1'b0, 1'b1, 3'd1, 16'd3);
    step(1'b0, 1'b1, 3'd4, 16'd1);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 3'd6, 16'd0);
    chk("R10 gate held without ticks", {15'd0, toneGate[0]}, 16'd1);
    #1 chk("R10 no flags without ticks", regRdData, 16'd0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'd6, 16'd0);
    step(1'b0, 1'b0, 3'd6, 16'd0);
    chk("R10 gate off after third tick", {15'd0, toneGate[0]}, 16'd0);
    #1 chk("R10 on-end flag", regRdData, 16'h1);
    step(1'b0, 1'b1, 3'd4, 16'd0);
    step(1'b0, 1'b1, 3'd6, 16'hF);
    idle(2);

    // R5: flags set with enables off, channel 2 bits
    step(1'b0, 1'b1, 3'd5, 16'd0);
    step(1'b0, 1'b1, 3'd2, 16'd1);
    step(1'b0, 1'b1, 3'd3, 16'd1);
    step(1'b0, 1'b1, 3'd4, 16'd2);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 3'd6, 16'd0);
    #1 chk("R5 channel 2 flags", regRdData & 16'hC, 16'hC);
    chk("R7 irq masked", {15'd0, irq}, 16'd0);
    step(1'b0, 1'b1, 3'd5, 16'h4);
    step(1'b0, 1'b0, 3'd6, 16'd0);
    chk("R7 irq enabled", {15'd0, irq}, 16'd1);
    step(1'b0, 1'b1, 3'd4, 16'd0);
    step(1'b0, 1'b1, 3'd6, 16'hF);
    idle(2);

    // R6: clear on the same edge as the event
    step(1'b0, 1'b1, 3'd5, 16'hF);
    step(1'b0, 1'b1, 3'd0, 16'd2);
    step(1'b0, 1'b1, 3'd1, 16'd2);
    step(1'b0, 1'b1, 3'd4, 16'd1);
    prevE = '0;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] e;
      @(posedge clk); #1;  // let the model settle before predicting the next edge
      e = predEvt(1'b1);
      if (e != 0) begin
        step(1'b1, 1'b1, 3'd6, {12'd0, e});
        nColl++;
      end else step(1'b1, 1'b0, 3'd6, 16'd0);
      if (prevE != 0) chk("R6 event beats clear", regRdData & {12'd0, prevE}, {12'd0, prevE});
      prevE = e;
    end
    chk("R6 collisions provoked", {15'd0, nColl > 0}, 16'd1);
    step(1'b0, 1'b1, 3'd4, 16'd0);
    idle(2);
    step(1'b0, 1'b1, 3'd6, 16'hF);
    idle(1);
    #1 chk("R6 clear without event", regRdData, 16'd0);

    // Random mix, with some clears aimed at predicted events
    for (int i = 0; i < 3000; i++) begin
      logic tk, we;
      logic [2:0] a;
      logic [15:0] d;
      logic [3:0] e;
      tk = ($urandom % 3) == 0;
      we = ($urandom % 4) == 0;
      a  = 3'($urandom % 8);
      d  = (a < 3'd4) ? 16'($urandom % 5) : 16'($urandom);
      @(posedge clk); #1;
      e = predEvt(tk);
      if (e != 0 && ($urandom % 3) == 0) begin
        we = 1'b1; a = 3'd6; d = {12'd0, e};
        nColl++;
      end
      step(tk, we, a, d);
    end
    idle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule